// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Expander

This block gathers a large field of single-cycle peripheral event pulses and folds them onto a small set of CPU interrupt lines. Sources are arranged in groups of eight, and each group drives one CPU line. Every source has its own pending flag and enable bit. Every group has a gate bit that closes when the group passes a request upward, and it stays closed until software reopens it. Above the groups sits a bank of per-line CPU flags and enables, followed by a single global mask.

The CPU sees one request output, the number of the winning line, and a flat vector index that names the winning source. When the CPU accepts the request (the vector fetch), the block does four things: it clears the CPU flag for that line, clears the winning source's pending flag, saves the global mask and sets it for the duration of the handler. A return strobe restores the saved mask. A software-interrupt strobe clears the CPU flag of a chosen line. All configuration goes through a small write port with a two-bit selector.

Top module: `pie_expander`

## Requirements
- R1: After reset, every source flag, source enable, group gate bit, CPU flag and CPU enable is 0, the global mask is set (masked), and `irq_valid` is 0.
- R2: A one-cycle pulse on `src_pulse` bit g*8+i sets the pending flag of source i in group g on the next clock edge. If that source is enabled and its group gate is open, the CPU flag of line g is set on the following edge.
- R3: A group passes a request upward only while at least one of its sources is both pending and enabled and its gate bit is clear. Pending sources that are disabled, or that sit in a group whose gate is closed, leave the CPU flag untouched.
- R4: On the edge where a group passes a request, its gate bit is set. Writing selector 1 (gate release) clears the gate bit of every group g whose `wr_data` bit g is 1. Groups whose bit is 0 are not affected.
- R5: A CPU flag is cleared by a vector fetch (`cpu_ack` while `irq_valid`) on that line, or by `swi_valid` with `swi_line` naming it. A set from the group wins over either clear in the same cycle.
- R6: `irq_valid` is 1 only when some line has both its CPU flag and its CPU enable set and the global mask is clear. Among such lines, the lowest-numbered one is reported on `irq_line`.
- R7: A vector fetch sets the global mask and saves its previous value. A `cpu_ret` pulse restores the saved value, so a second pending line is held off until the return.
- R8: Within the winning group, the lowest-numbered source that is pending and enabled is chosen, and `vec_idx` = `irq_line`*8 + that source index.
- R9: A vector fetch clears only the winning source's pending flag. Other pending sources of the same group stay pending and are forwarded after the gate is released.
- R10: Write selector codes: 0 loads the enables of group `wr_group` from `wr_data[7:0]`; 2 loads the CPU enables from `wr_data[11:0]` (bit n = line n); 3 loads the global mask from `wr_data[0]` (1 = masked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 96 | Event pulses; bit g*8+i is source i of group g |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 source enables, 1 gate release, 2 CPU enables, 3 global mask |
| wr_group | input | 4 | Group addressed by a source-enable write |
| wr_data | input | 12 | Write data |
| cpu_ack | input | 1 | Vector fetch by the CPU for the current request |
| cpu_ret | input | 1 | Return from the handler; restores the mask |
| swi_valid | input | 1 | Software interrupt executed |
| swi_line | input | 4 | Line targeted by the software interrupt |
| irq_valid | output | 1 | Interrupt request to the CPU |
| irq_line | output | 4 | Winning CPU line |
| vec_idx | output | 7 | Flat index of the winning source |

## Verification
A source pulse sampled on edge N sets the source flag at N, the CPU flag at N+1, and shows up on `irq_valid`/`vec_idx` after N+1, two edges in all. A gate release, enable write or mask write takes effect on its edge and is visible one edge later for gate and source enables, or right away for the mask and CPU enables. The bench drives every input on the falling edge and reads results in the middle of the low phase after the counted number of rising edges. The monitor compares each fetched vector against the scoreboard queue at the moment of the fetch. Stimulus that should not raise a request is checked over several cycles before the release that should.

// File: rtl/pie_pkg.sv
package pie_pkg;

    typedef enum logic [1:0] {
        SEL_SRC_EN  = 2'd0,
        SEL_GATE_RL = 2'd1,
        SEL_CPU_EN  = 2'd2,
        SEL_GMASK   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } pick_t;

    localparam int PICK_W = 16;

    // Lowest set bit of a vector of up to 16 bits.
    function automatic pick_t pick_lowest(input logic [PICK_W-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = PICK_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = 4'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pie_group.sv
module pie_group
    import pie_pkg::*;
#(
    parameter int NS     = 8,
    parameter int SIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NS-1:0]     src_pulse,
    input  logic              en_wr,
    input  logic [NS-1:0]     en_data,
    input  logic              gate_release,
    input  logic              take_win,
    output logic              fwd,
    output logic              gate_q,
    output logic [SIDX_W-1:0] win_idx
);

    logic [NS-1:0] flag_q;
    logic [NS-1:0] en_q;
    logic [NS-1:0] live;
    logic [NS-1:0] win_mask;
    pick_t         pick;

    assign live = flag_q & en_q;

    always_comb begin
        pick    = pick_lowest(PICK_W'(live));
        win_idx = SIDX_W'(pick.idx);
        fwd     = pick.hit & ~gate_q;
    end

    always_comb begin
        win_mask = '0;
        for (int i = 0; i < NS; i++) begin
            win_mask[i] = take_win && (SIDX_W'(i) == win_idx);
        end
    end

    // A new pulse wins over the fetch-clear of the same source.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~win_mask) | src_pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (fwd) begin
            gate_q <= 1'b1;
        end else if (gate_release) begin
            gate_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pie_cpu_core.sv
module pie_cpu_core
    import pie_pkg::*;
#(
    parameter int NG     = 12,
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NG-1:0]     grp_fwd,
    input  logic              en_wr,
    input  logic [NG-1:0]     en_data,
    input  logic              mask_wr,
    input  logic              mask_data,
    input  logic              cpu_ack,
    input  logic              cpu_ret,
    input  logic              swi_valid,
    input  logic [LINE_W-1:0] swi_line,
    output logic              irq_valid,
    output logic [LINE_W-1:0] irq_line,
    output logic [NG-1:0]     cpu_flag
);

    logic [NG-1:0] cpu_en_q;
    logic [NG-1:0] pending;
    logic          gmask_q;
    logic          gmask_saved_q;
    logic          taken;
    pick_t         pick;

    assign pending = cpu_flag & cpu_en_q;

    always_comb begin
        pick      = pick_lowest(PICK_W'(pending));
        irq_line  = LINE_W'(pick.idx);
        irq_valid = pick.hit & ~gmask_q;
    end

    assign taken = cpu_ack & irq_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_flag <= '0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                if (grp_fwd[g]) begin
                    cpu_flag[g] <= 1'b1;
                end else if ((taken && irq_line == LINE_W'(g)) ||
                             (swi_valid && swi_line == LINE_W'(g))) begin
                    cpu_flag[g] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_en_q <= '0;
        end else if (en_wr) begin
            cpu_en_q <= en_data;
        end
    end

    // Fetch beats return, return beats a software mask write.
    always_ff @(posedge clk) begin
        if (rst) begin
            gmask_q       <= 1'b1;
            gmask_saved_q <= 1'b1;
        end else if (taken) begin
            gmask_q       <= 1'b1;
            gmask_saved_q <= gmask_q;
        end else if (cpu_ret) begin
            gmask_q       <= gmask_saved_q;
        end else if (mask_wr) begin
            gmask_q       <= mask_data;
        end
    end

endmodule

// File: rtl/pie_expander.sv
module pie_expander
    import pie_pkg::*;
#(
    parameter int NUM_GROUPS    = 12,
    parameter int SRC_PER_GROUP = 8
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0]        src_pulse,
    input  logic                                       wr_en,
    input  logic [1:0]                                 wr_sel,
    input  logic [$clog2(NUM_GROUPS)-1:0]              wr_group,
    input  logic [((NUM_GROUPS > SRC_PER_GROUP) ? NUM_GROUPS : SRC_PER_GROUP)-1:0] wr_data,
    input  logic                                       cpu_ack,
    input  logic                                       cpu_ret,
    input  logic                                       swi_valid,
    input  logic [$clog2(NUM_GROUPS)-1:0]              swi_line,
    output logic                                       irq_valid,
    output logic [$clog2(NUM_GROUPS)-1:0]              irq_line,
    output logic [$clog2(NUM_GROUPS*SRC_PER_GROUP)-1:0] vec_idx
);

    localparam int NG     = NUM_GROUPS;
    localparam int NS     = SRC_PER_GROUP;
    localparam int LINE_W = $clog2(NG);
    localparam int SIDX_W = $clog2(NS);
    localparam int VEC_W  = $clog2(NG * NS);

    wr_sel_e sel;
    logic [NG-1:0]     grp_fwd;
    logic [NG-1:0]     grp_gate;
    logic [NG-1:0]     cpu_flag;
    logic [SIDX_W-1:0] grp_win [NG];
    logic [SIDX_W-1:0] sel_win;
    logic              taken;

    assign sel   = wr_sel_e'(wr_sel);
    assign taken = cpu_ack & irq_valid;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        pie_group #(
            .NS     (NS),
            .SIDX_W (SIDX_W)
        ) u_grp (
            .clk          (clk),
            .rst          (rst),
            .src_pulse    (src_pulse[g*NS +: NS]),
            .en_wr        (wr_en && sel == SEL_SRC_EN && wr_group == LINE_W'(g)),
            .en_data      (wr_data[NS-1:0]),
            .gate_release (wr_en && sel == SEL_GATE_RL && wr_data[g]),
            .take_win     (taken && irq_line == LINE_W'(g)),
            .fwd          (grp_fwd[g]),
            .gate_q       (grp_gate[g]),
            .win_idx      (grp_win[g])
        );
    end

    pie_cpu_core #(
        .NG     (NG),
        .LINE_W (LINE_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .grp_fwd   (grp_fwd),
        .en_wr     (wr_en && sel == SEL_CPU_EN),
        .en_data   (wr_data[NG-1:0]),
        .mask_wr   (wr_en && sel == SEL_GMASK),
        .mask_data (wr_data[0]),
        .cpu_ack   (cpu_ack),
        .cpu_ret   (cpu_ret),
        .swi_valid (swi_valid),
        .swi_line  (swi_line),
        .irq_valid (irq_valid),
        .irq_line  (irq_line),
        .cpu_flag  (cpu_flag)
    );

    always_comb begin
        sel_win = '0;
        for (int g = 0; g < NG; g++) begin
            if (irq_line == LINE_W'(g)) begin
                sel_win = grp_win[g];
            end
        end
    end

    assign vec_idx = VEC_W'(irq_line) * VEC_W'(NS) + VEC_W'(sel_win);

endmodule

// File: rtl/pie_checker.sv
module pie_checker #(
    parameter int NG = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [NG-1:0] grp_fwd,
    input logic [NG-1:0] grp_gate,
    input logic [NG-1:0] cpu_flag,
    input logic          irq_valid,
    input logic          cpu_ack
);

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> !irq_valid);

    p_entry_masks_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq_valid) |=> !irq_valid);

    for (genvar g = 0; g < NG; g++) begin : g_chk
        p_gate_blocks_r3: assert property (@(posedge clk) disable iff (rst)
            grp_gate[g] |-> !grp_fwd[g]);

        p_fwd_closes_gate_r4: assert property (@(posedge clk) disable iff (rst)
            grp_fwd[g] |=> grp_gate[g]);

        p_line_flag_source_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(cpu_flag[g]) |-> $past(grp_fwd[g]));
    end

endmodule

bind pie_expander pie_checker #(.NG(NUM_GROUPS)) u_pie_checker (
    .clk       (clk),
    .rst       (rst),
    .grp_fwd   (grp_fwd),
    .grp_gate  (grp_gate),
    .cpu_flag  (cpu_flag),
    .irq_valid (irq_valid),
    .cpu_ack   (cpu_ack)
);

// File: tb/test_pie_expander.sv
`timescale 1ns/1ps
module test_pie_expander;

    localparam int NG = 12;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [95:0]   src_pulse = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [3:0]    wr_group = '0;
    logic [11:0]   wr_data = '0;
    logic          cpu_ack = 1'b0;
    logic          cpu_ret = 1'b0;
    logic          swi_valid = 1'b0;
    logic [3:0]    swi_line = '0;
    logic          irq_valid;
    logic [3:0]    irq_line;
    logic [6:0]    vec_idx;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    event take_ev;

    always #2 clk = ~clk;

    pie_expander #(.NUM_GROUPS(NG), .SRC_PER_GROUP(NS)) i_pie_expander (
        .clk, .rst, .src_pulse, .wr_en, .wr_sel, .wr_group, .wr_data,
        .cpu_ack, .cpu_ret, .swi_valid, .swi_line,
        .irq_valid, .irq_line, .vec_idx
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse(input logic [95:0] bits);
        @(negedge clk) src_pulse = bits;
        @(negedge clk) src_pulse = '0;
    endtask

    task automatic wr(input int sel, input int grp, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_group = 4'(grp); wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver side of the scoreboard.
    task automatic expect_irq(input int line, input int vec);
        exp_q.push_back(line * 256 + vec);
    endtask

    // Fetch the current request; the monitor compares it mid-cycle.
    task automatic take();
        ->take_ev;
        #0.5;
        cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        check("R7 mask set after fetch", int'(irq_valid), 0);
    endtask

    task automatic ret();
        @(negedge clk) cpu_ret = 1'b1;
        @(negedge clk) cpu_ret = 1'b0;
    endtask

    // Monitor side of the scoreboard.
    initial begin
        forever begin
            @(take_ev);
            if (exp_q.size() == 0) begin
                check("R6 unexpected fetch (queue empty)", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R6 irq_valid at fetch", int'(irq_valid), 1);
                check("R6 winning line", int'(irq_line), e / 256);
                check("R8 vec_idx", int'(vec_idx), e % 256);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 irq_valid after reset", int'(irq_valid), 0);

        // R10 configuration
        wr(2, 0, 12'hFFF);
        wr(0, 0, 8'hFF);
        wr(0, 2, 8'hFF);
        wr(0, 5, 8'h0F);
        check("R1 R10 still masked", int'(irq_valid), 0);
        wr(3, 0, 0);

        // R2 single source, two edges to the output
        @(negedge clk) src_pulse = 96'(1) << 21;
        @(negedge clk) src_pulse = '0;
        check("R2 not yet visible after one edge", int'(irq_valid), 0);
        @(negedge clk);
        expect_irq(2, 21);
        take();
        ret();
        check("R7 mask restored, nothing pending", int'(irq_valid), 0);

        // R3 gate closed blocks group 2; R4 release reopens it
        pulse(96'(1) << 20);
        cyc(3);
        check("R3 closed gate blocks", int'(irq_valid), 0);
        wr(1, 0, 12'h004);
        @(negedge clk);
        expect_irq(2, 20);
        take();
        ret();

        // R4 zero bits in the release word leave the gate closed
        pulse(96'(1) << 17);
        wr(1, 0, 12'hFFB);
        cyc(3);
        check("R4 zero bit leaves gate closed", int'(irq_valid), 0);
        wr(1, 0, 12'h004);
        @(negedge clk);
        expect_irq(2, 17);
        take();
        ret();

        // R3 disabled source is not forwarded until enabled
        pulse(96'(1) << 46);
        cyc(3);
        check("R3 disabled source blocked", int'(irq_valid), 0);
        wr(0, 5, 8'hFF);
        @(negedge clk);
        expect_irq(5, 46);
        take();
        ret();

        // R6 R8 R7 R9 priorities and held second line
        wr(1, 0, 12'hFFF);
        pulse((96'(1) << 3) | (96'(1) << 1) | (96'(1) << 23));
        @(negedge clk);
        expect_irq(0, 1);
        take();
        check("R7 line 2 held off while masked", int'(irq_valid), 0);
        ret();
        expect_irq(2, 23);
        take();
        ret();
        check("R9 remaining source waits for gate", int'(irq_valid), 0);
        wr(1, 0, 12'h001);
        @(negedge clk);
        expect_irq(0, 3);
        take();
        ret();

        // R10 global mask write
        wr(3, 0, 1);
        wr(1, 0, 12'hFFF);
        pulse(96'(1) << 0);
        cyc(3);
        check("R10 masked holds request", int'(irq_valid), 0);
        wr(3, 0, 0);
        expect_irq(0, 0);
        take();
        ret();

        // R6 CPU enable gating, R5 software interrupt clears line flag
        wr(2, 0, 12'hFFE);
        wr(1, 0, 12'hFFF);
        pulse(96'(1) << 2);
        cyc(3);
        check("R6 disabled line not requested", int'(irq_valid), 0);
        @(negedge clk) begin swi_valid = 1'b1; swi_line = 4'd0; end
        @(negedge clk) swi_valid = 1'b0;
        wr(2, 0, 12'hFFF);
        cyc(1);
        check("R5 swi cleared line flag", int'(irq_valid), 0);

        check("R6 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule